// File: doc/BRIEF.md
# Snoop-Coherent Victim Buffer

This block is a small, fully associative store that sits beside one core's private first-level cache in a multiprocessor whose caches keep coherent by watching a shared snoop bus. Lines that the first-level cache throws out are parked here. A later miss in the first-level cache probes the buffer, and on a hit the line moves back to the core together with its dirty flag. The core can evict a line and take one back in the same cycle, so a swap costs one cycle.

The buffer takes full part in coherence. Each entry is Invalid, Shared (clean) or Modified (dirty, and the only valid copy in the system). A remote read that hits a Modified entry makes the buffer supply the line and hold off memory, and the entry becomes Shared. A remote write or invalidate drops the entry, and the buffer supplies the data first if the entry was dirty. Because of this, a line that another core has since written can never be handed back to the local core. If a snoop and a local transfer name the same line in the same cycle, the snoop is served and the local request is told to retry.

Top module: `snoop_victim_buffer`

## Requirements
- R1: After reset every entry is Invalid: every lookup misses, and lookupHit, lookupMiss, memInhibit and wbValid are low.
- R2: A clean eviction (evictDirty=0) followed by a lookup of the same line address gives lookupHit one cycle after the lookup, with the stored data and lookupDirty=0. The entry is then removed, so a second lookup gives lookupMiss.
- R3: A dirty eviction (evictDirty=1) followed by a lookup returns the data with lookupDirty=1.
- R4: An invalidating snoop (snoopKind=1) that hits a clean entry removes it without raising memInhibit. A later lookup of that line misses, so the sequence evict, remote write, local re-read ends in a miss.
- R5: A read snoop (snoopKind=0) that hits a dirty entry raises memInhibit one cycle later with the line on snoopData. The entry stays and becomes clean, so a later lookup hits with lookupDirty=0.
- R6: An invalidating snoop that hits a dirty entry raises memInhibit one cycle later with the line on snoopData, and the entry is removed.
- R7: A read snoop that hits a clean entry leaves memInhibit low and leaves the entry in place and clean.
- R8: When lookupValid and snoopValid are both high with equal addresses, lookupRetry is high in that cycle. The lookup gets no response (lookupHit and lookupMiss stay low), and the snoop is served normally.
- R9: When evictValid and snoopValid are both high with equal addresses, evictRetry is high in that cycle and the line is not stored.
- R10: An eviction into a full buffer replaces entries in round-robin order. Slot 0 is replaced first after reset, and slots are filled lowest-index first while any is free. A replaced dirty entry appears on wbValid/wbAddr/wbData one cycle later. A replaced clean entry produces no write-back.
- R11: A lookup hit and an eviction in the same cycle, with the buffer full, store the evicted line in the slot freed by the hit, with no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evictValid | input | 1 | First-level cache pushes out a line |
| evictAddr | input | ADDR_W | Line address of the evicted line |
| evictData | input | DATA_W | Evicted line contents |
| evictDirty | input | 1 | Evicted line is modified |
| evictRetry | output | 1 | Eviction refused this cycle; present again |
| lookupValid | input | 1 | First-level miss probes the buffer |
| lookupAddr | input | ADDR_W | Line address probed |
| lookupRetry | output | 1 | Probe refused this cycle; present again |
| lookupHit | output | 1 | Probe one cycle ago hit; line handed over |
| lookupMiss | output | 1 | Probe one cycle ago missed |
| lookupData | output | DATA_W | Line returned on a hit |
| lookupDirty | output | 1 | Returned line is modified |
| snoopValid | input | 1 | Remote transaction on the snoop bus |
| snoopAddr | input | ADDR_W | Snooped line address |
| snoopKind | input | 1 | 0 = remote read, 1 = remote write or invalidate |
| memInhibit | output | 1 | Buffer supplies the snooped line in place of memory |
| snoopData | output | DATA_W | Line supplied to the snoop bus |
| wbValid | output | 1 | Dirty line displaced by replacement |
| wbAddr | output | ADDR_W | Address of the displaced line |
| wbData | output | DATA_W | Contents of the displaced line |

## Verification
The bench walks every pairing of snoop kind and entry state, so a buffer that ignored invalidations would hand back a stale line on the re-read, and one that failed to downgrade would report a dirty line after a remote read. It collides snoops with probes and with evictions in the same cycle; a design without the retry rule would either return a line the snoop had just dropped or store a line that had just lost ownership. The bench fills the buffer and then overflows it, with dirty and clean slots alternating. A wrong replacement order or a missing write-back shows up as a wrong or absent write-back address. Finally, a probe hit and an eviction arrive together in a full buffer of dirty lines. A design that did not reuse the freed slot would displace a dirty line and raise a write-back.

// File: rtl/vbuf_pkg.sv
package vbuf_pkg;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_MOD = 2'd2
  } lineState_t;

  // per-cycle commands from control to datapath
  typedef struct packed {
    logic allocEn;
    logic allocMod;
    logic lookupTake;
    logic lookupMiss;
    logic snoopDrop;
    logic snoopDown;
    logic snoopSupply;
    logic wbEn;
  } vbStrobe_t;

endpackage

// File: rtl/vbuf_datapath.sv
module vbuf_datapath
  import vbuf_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  vbStrobe_t         strobe,
  input  logic [IDX_W-1:0]  allocIdx,
  input  logic [IDX_W-1:0]  lookupIdx,
  input  logic [IDX_W-1:0]  snoopIdx,
  input  logic [ADDR_W-1:0] evictAddr,
  input  logic [DATA_W-1:0] evictData,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] modVec,
  output logic [ENTRIES-1:0] lookupHitVec,
  output logic [ENTRIES-1:0] snoopHitVec,
  output logic              lookupHit,
  output logic              lookupMiss,
  output logic [DATA_W-1:0] lookupData,
  output logic              lookupDirty,
  output logic              memInhibit,
  output logic [DATA_W-1:0] snoopData,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData
);

  lineState_t        stateQ [ENTRIES];
  logic [ADDR_W-1:0] tagQ   [ENTRIES];
  logic [DATA_W-1:0] dataQ  [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_match
    assign validVec[e]     = (stateQ[e] != LN_INV);
    assign modVec[e]       = (stateQ[e] == LN_MOD);
    assign lookupHitVec[e] = validVec[e] && (tagQ[e] == lookupAddr);
    assign snoopHitVec[e]  = validVec[e] && (tagQ[e] == snoopAddr);
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (!rstN) begin
        stateQ[e] <= LN_INV;
        tagQ[e]   <= '0;
        dataQ[e]  <= '0;
      end else if (strobe.allocEn && allocIdx == IDX_W'(e)) begin
        stateQ[e] <= strobe.allocMod ? LN_MOD : LN_SHR;
        tagQ[e]   <= evictAddr;
        dataQ[e]  <= evictData;
      end else if ((strobe.lookupTake && lookupIdx == IDX_W'(e)) ||
                   (strobe.snoopDrop && snoopIdx == IDX_W'(e))) begin
        stateQ[e] <= LN_INV;
      end else if (strobe.snoopDown && snoopIdx == IDX_W'(e)) begin
        stateQ[e] <= LN_SHR;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lookupHit   <= 1'b0;
      lookupMiss  <= 1'b0;
      lookupData  <= '0;
      lookupDirty <= 1'b0;
      memInhibit  <= 1'b0;
      snoopData   <= '0;
      wbValid     <= 1'b0;
      wbAddr      <= '0;
      wbData      <= '0;
    end else begin
      lookupHit   <= strobe.lookupTake;
      lookupMiss  <= strobe.lookupMiss;
      lookupData  <= dataQ[lookupIdx];
      lookupDirty <= strobe.lookupTake && (stateQ[lookupIdx] == LN_MOD);
      memInhibit  <= strobe.snoopSupply;
      snoopData   <= dataQ[snoopIdx];
      wbValid     <= strobe.wbEn;
      wbAddr      <= tagQ[allocIdx];
      wbData      <= dataQ[allocIdx];
    end
  end

endmodule

// File: rtl/vbuf_control.sv
module vbuf_control
  import vbuf_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 12,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               evictValid,
  input  logic [ADDR_W-1:0]  evictAddr,
  input  logic               evictDirty,
  input  logic               lookupValid,
  input  logic [ADDR_W-1:0]  lookupAddr,
  input  logic               snoopValid,
  input  logic [ADDR_W-1:0]  snoopAddr,
  input  logic               snoopKind,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] modVec,
  input  logic [ENTRIES-1:0] lookupHitVec,
  input  logic [ENTRIES-1:0] snoopHitVec,
  output vbStrobe_t          strobe,
  output logic [IDX_W-1:0]   allocIdx,
  output logic [IDX_W-1:0]   lookupIdx,
  output logic [IDX_W-1:0]   snoopIdx,
  output logic               lookupRetry,
  output logic               evictRetry
);

  logic [IDX_W-1:0]   rrPtr;
  logic [IDX_W-1:0]   firstFree;
  logic [ENTRIES-1:0] freeVec;
  logic               anyFree, snoopHit, snoopMod;

  always_comb begin
    lookupIdx = '0;
    snoopIdx  = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (lookupHitVec[e]) lookupIdx = lookupIdx | IDX_W'(e);
      if (snoopHitVec[e])  snoopIdx  = snoopIdx  | IDX_W'(e);
    end
  end

  assign snoopHit    = snoopValid && (|snoopHitVec);
  assign snoopMod    = modVec[snoopIdx];
  assign lookupRetry = lookupValid && snoopValid && (lookupAddr == snoopAddr);

  assign strobe.lookupTake  = lookupValid && !lookupRetry && (|lookupHitVec);
  assign strobe.lookupMiss  = lookupValid && !lookupRetry && !(|lookupHitVec);
  assign strobe.snoopSupply = snoopHit && snoopMod;
  assign strobe.snoopDrop   = snoopHit && snoopKind;
  assign strobe.snoopDown   = snoopHit && !snoopKind && snoopMod;

  // a slot handed back to the core this cycle is free for the incoming victim
  assign freeVec = ~validVec | (strobe.lookupTake ? lookupHitVec : '0);
  assign anyFree = |freeVec;

  always_comb begin
    firstFree = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (freeVec[e]) firstFree = IDX_W'(e);
    end
  end

  assign evictRetry = evictValid && snoopValid &&
                      ((evictAddr == snoopAddr) ||
                       (!anyFree && snoopHit && snoopIdx == rrPtr));

  assign allocIdx        = anyFree ? firstFree : rrPtr;
  assign strobe.allocEn  = evictValid && !evictRetry;
  assign strobe.allocMod = evictDirty;
  assign strobe.wbEn     = strobe.allocEn && !anyFree && modVec[rrPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (strobe.allocEn && !anyFree) begin
      rrPtr <= (rrPtr == IDX_W'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
    end
  end

endmodule

// File: rtl/snoop_victim_buffer.sv
module snoop_victim_buffer
  import vbuf_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evictValid,
  input  logic [ADDR_W-1:0] evictAddr,
  input  logic [DATA_W-1:0] evictData,
  input  logic              evictDirty,
  output logic              evictRetry,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              lookupRetry,
  output logic              lookupHit,
  output logic              lookupMiss,
  output logic [DATA_W-1:0] lookupData,
  output logic              lookupDirty,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic              snoopKind,
  output logic              memInhibit,
  output logic [DATA_W-1:0] snoopData,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  vbStrobe_t          strobe;
  logic [IDX_W-1:0]   allocIdx, lookupIdx, snoopIdx;
  logic [ENTRIES-1:0] validVec, modVec, lookupHitVec, snoopHitVec;

  vbuf_control #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk, .rstN,
    .evictValid, .evictAddr, .evictDirty,
    .lookupValid, .lookupAddr,
    .snoopValid, .snoopAddr, .snoopKind,
    .validVec, .modVec, .lookupHitVec, .snoopHitVec,
    .strobe, .allocIdx, .lookupIdx, .snoopIdx,
    .lookupRetry, .evictRetry
  );

  vbuf_datapath #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk, .rstN, .strobe,
    .allocIdx, .lookupIdx, .snoopIdx,
    .evictAddr, .evictData, .lookupAddr, .snoopAddr,
    .validVec, .modVec, .lookupHitVec, .snoopHitVec,
    .lookupHit, .lookupMiss, .lookupData, .lookupDirty,
    .memInhibit, .snoopData,
    .wbValid, .wbAddr, .wbData
  );

endmodule

// File: rtl/snoop_victim_buffer_checker.sv
module snoop_victim_buffer_checker #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              evictValid,
  input logic [ADDR_W-1:0] evictAddr,
  input logic [DATA_W-1:0] evictData,
  input logic              evictDirty,
  input logic              evictRetry,
  input logic              lookupValid,
  input logic [ADDR_W-1:0] lookupAddr,
  input logic              lookupRetry,
  input logic              lookupHit,
  input logic              lookupMiss,
  input logic [DATA_W-1:0] lookupData,
  input logic              lookupDirty,
  input logic              snoopValid,
  input logic [ADDR_W-1:0] snoopAddr,
  input logic              snoopKind,
  input logic              memInhibit,
  input logic [DATA_W-1:0] snoopData,
  input logic              wbValid,
  input logic [ADDR_W-1:0] wbAddr,
  input logic [DATA_W-1:0] wbData
);

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !lookupHit && !lookupMiss && !memInhibit && !wbValid);

  p_resp_needs_probe_r2: assert property (@(posedge clk) disable iff (!rstN)
    (lookupHit || lookupMiss) |-> $past(lookupValid));

  p_hit_miss_exclusive_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(lookupHit && lookupMiss));

  p_inhibit_needs_snoop_r5: assert property (@(posedge clk) disable iff (!rstN)
    memInhibit |-> $past(snoopValid));

  p_retry_no_response_r8: assert property (@(posedge clk) disable iff (!rstN)
    lookupRetry |=> !lookupHit && !lookupMiss);

  p_evict_retry_no_wb_r9: assert property (@(posedge clk) disable iff (!rstN)
    evictRetry |=> !wbValid);

  p_wb_needs_evict_r10: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> $past(evictValid));

endmodule

bind snoop_victim_buffer snoop_victim_buffer_checker #(
  .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/snoop_victim_buffer_test.sv
module snoop_victim_buffer_test;

  localparam int ENTRIES = 4;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              evictValid = 1'b0, evictDirty = 1'b0;
  logic [ADDR_W-1:0] evictAddr = '0;
  logic [DATA_W-1:0] evictData = '0;
  logic              lookupValid = 1'b0;
  logic [ADDR_W-1:0] lookupAddr = '0;
  logic              snoopValid = 1'b0, snoopKind = 1'b0;
  logic [ADDR_W-1:0] snoopAddr = '0;
  logic              evictRetry, lookupRetry, lookupHit, lookupMiss, lookupDirty;
  logic              memInhibit, wbValid;
  logic [DATA_W-1:0] lookupData, snoopData, wbData;
  logic [ADDR_W-1:0] wbAddr;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  snoop_victim_buffer #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk, .rstN,
    .evictValid, .evictAddr, .evictData, .evictDirty, .evictRetry,
    .lookupValid, .lookupAddr, .lookupRetry, .lookupHit, .lookupMiss,
    .lookupData, .lookupDirty,
    .snoopValid, .snoopAddr, .snoopKind, .memInhibit, .snoopData,
    .wbValid, .wbAddr, .wbData
  );

  function automatic logic [DATA_W-1:0] dat(input logic [ADDR_W-1:0] a);
    return {a, 8'h5A, ~a};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic doEvict(input logic [ADDR_W-1:0] a, input logic dirty, input string req);
    evictValid = 1'b1; evictAddr = a; evictData = dat(a); evictDirty = dirty;
    #1;
    chk(evictRetry === 1'b0, req, 64'(evictRetry), 64'd0);
    tick();
    evictValid = 1'b0;
  endtask

  task automatic doLookup(input logic [ADDR_W-1:0] a, input logic expHit,
                          input logic expDirty, input string req);
    lookupValid = 1'b1; lookupAddr = a;
    tick();
    lookupValid = 1'b0;
    chk(lookupHit === expHit && lookupMiss === !expHit, req,
        {62'd0, lookupHit, lookupMiss}, {62'd0, expHit, !expHit});
    if (expHit) begin
      chk(lookupData === dat(a), req, 64'(lookupData), 64'(dat(a)));
      chk(lookupDirty === expDirty, req, 64'(lookupDirty), 64'(expDirty));
    end
  endtask

  task automatic doSnoop(input logic [ADDR_W-1:0] a, input logic kind,
                         input logic expInh, input string req);
    snoopValid = 1'b1; snoopAddr = a; snoopKind = kind;
    tick();
    snoopValid = 1'b0;
    chk(memInhibit === expInh, req, 64'(memInhibit), 64'(expInh));
    if (expInh) chk(snoopData === dat(a), req, 64'(snoopData), 64'(dat(a)));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    chk(!lookupHit && !lookupMiss && !memInhibit && !wbValid, "R1",
        {60'd0, lookupHit, lookupMiss, memInhibit, wbValid}, 64'd0);
    for (int i = 0; i < ENTRIES; i++) doLookup(ADDR_W'(i), 1'b0, 1'b0, "R1");

    // R2 / R3: clean and dirty round trips, entry removed after hand-back
    for (int i = 0; i < ENTRIES; i++) doEvict(ADDR_W'(12'h100 + i), i[0], "R2");
    for (int i = 0; i < ENTRIES; i++)
      doLookup(ADDR_W'(12'h100 + i), 1'b1, i[0], i[0] ? "R3" : "R2");
    for (int i = 0; i < ENTRIES; i++) doLookup(ADDR_W'(12'h100 + i), 1'b0, 1'b0, "R2");

    // R4..R7: every snoop kind against every entry state
    for (int kind = 0; kind < 2; kind++) begin
      for (int dirty = 0; dirty < 2; dirty++) begin
        string req;
        logic [ADDR_W-1:0] a;
        a = ADDR_W'(12'h200 + kind * 2 + dirty);
        req = (kind == 0) ? (dirty != 0 ? "R5" : "R7") : (dirty != 0 ? "R6" : "R4");
        doEvict(a, dirty[0], req);
        doSnoop(a, kind[0], dirty[0], req);
        doLookup(a, kind == 0, 1'b0, req);
      end
    end

    // R8: snoop and probe on the same line collide
    doEvict(12'h300, 1'b1, "R8");
    lookupValid = 1'b1; lookupAddr = 12'h300;
    snoopValid = 1'b1; snoopAddr = 12'h300; snoopKind = 1'b0;
    #1;
    chk(lookupRetry === 1'b1, "R8", 64'(lookupRetry), 64'd1);
    tick();
    lookupValid = 1'b0; snoopValid = 1'b0;
    chk(!lookupHit && !lookupMiss, "R8", {62'd0, lookupHit, lookupMiss}, 64'd0);
    chk(memInhibit === 1'b1 && snoopData === dat(12'h300), "R8",
        64'(snoopData), 64'(dat(12'h300)));
    doLookup(12'h300, 1'b1, 1'b0, "R8");
    lookupValid = 1'b1; lookupAddr = 12'h301;
    snoopValid = 1'b1; snoopAddr = 12'h302; snoopKind = 1'b0;
    #1;
    chk(lookupRetry === 1'b0, "R8", 64'(lookupRetry), 64'd0);
    tick();
    lookupValid = 1'b0; snoopValid = 1'b0;

    // R9: snoop and eviction on the same line collide
    evictValid = 1'b1; evictAddr = 12'h310; evictData = dat(12'h310); evictDirty = 1'b1;
    snoopValid = 1'b1; snoopAddr = 12'h310; snoopKind = 1'b1;
    #1;
    chk(evictRetry === 1'b1, "R9", 64'(evictRetry), 64'd1);
    tick();
    evictValid = 1'b0; snoopValid = 1'b0;
    doLookup(12'h310, 1'b0, 1'b0, "R9");

    // R10: fill, then overflow in round-robin order with alternating dirty slots
    for (int i = 0; i < ENTRIES; i++) begin
      doEvict(ADDR_W'(12'h400 + i), i[0], "R10");
      chk(wbValid === 1'b0, "R10", 64'(wbValid), 64'd0);
    end
    for (int j = 0; j < ENTRIES; j++) begin
      doEvict(ADDR_W'(12'h500 + j), 1'b1, "R10");
      chk(wbValid === j[0], "R10", 64'(wbValid), 64'(j[0]));
      if (j[0]) begin
        chk(wbAddr === ADDR_W'(12'h400 + j), "R10", 64'(wbAddr), 64'(12'h400 + j));
        chk(wbData === dat(ADDR_W'(12'h400 + j)), "R10", 64'(wbData),
            64'(dat(ADDR_W'(12'h400 + j))));
      end
    end

    // R11: swap in a full buffer of dirty lines reuses the freed slot
    lookupValid = 1'b1; lookupAddr = 12'h501;
    evictValid = 1'b1; evictAddr = 12'h600; evictData = dat(12'h600); evictDirty = 1'b0;
    #1;
    chk(evictRetry === 1'b0 && lookupRetry === 1'b0, "R11",
        {62'd0, evictRetry, lookupRetry}, 64'd0);
    tick();
    lookupValid = 1'b0; evictValid = 1'b0;
    chk(lookupHit === 1'b1 && lookupData === dat(12'h501) && lookupDirty === 1'b1, "R11",
        64'(lookupData), 64'(dat(12'h501)));
    chk(wbValid === 1'b0, "R11", 64'(wbValid), 64'd0);
    doLookup(12'h600, 1'b1, 1'b0, "R11");
    doLookup(12'h500, 1'b1, 1'b1, "R11");
    doLookup(12'h502, 1'b1, 1'b1, "R11");
    doLookup(12'h503, 1'b1, 1'b1, "R11");
    for (int i = 0; i < ENTRIES; i++) doLookup(ADDR_W'(12'h400 + i), 1'b0, 1'b0, "R10");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule